// File: doc/BRIEF.md
# Paged Memory Translation Unit

This block turns CPU addresses in the low 4 MiB RAM window into physical RAM addresses. The window is split into 4 KiB pages, and each page has one 16-bit entry in an on-chip map table. An entry holds a physical page number, a write-enable flag and a two-bit page state. Addresses above the window leave the unit unchanged. Permission checks and the RAM itself sit elsewhere.

Every access strobe reads the entry for its page. A registered result comes out one cycle later with the translated address, the page state the access saw and the entry's write-enable flag. The same lookup also updates the entry's history in hardware. An untouched page becomes read or dirty, and a read page becomes dirty when it is written. A separate load port fills the table.

Strobes may arrive on every cycle. A strobe that hits the page of the strobe just before it sees that strobe's update. A load wins over a history update that lands on the same cycle.

Top module: `page_map_unit`

## Requirements
- R1: An address at or above 0x400000 passes to `xl_addr` unchanged, with `xl_mapped`, `xl_state` and `xl_wen` all 0, and the table is left alone.
- R2: An address below 0x400000 uses bits 21:12 as the entry index and bits 11:0 as the offset. The output is the entry's page number (map word bits 9:0) shifted left by 12, plus the offset, with bits 23:22 zero.
- R3: A strobe sampled on clock edge k gives `xl_vld` high for exactly one cycle after edge k+1. Strobes are accepted on every cycle. With no strobe, `xl_vld` is low.
- R4: Map word bit 15 is the write-enable flag and bits 14:13 are the page state (0 absent, 1 untouched, 2 read, 3 dirty). A mapped result reports bit 15 on `xl_wen` and, on `xl_state`, the state as it was before this access.
- R5: Access to an entry in state 1 moves it to state 3 for a write and to state 2 for a read.
- R6: A write to an entry in state 2 moves it to 3. A read leaves state 2 as it is, and state 3 never changes.
- R7: Access to an entry in state 0 leaves the entry unchanged.
- R8: A state update never alters the write-enable flag or the page number of the entry.
- R9: A strobe to the same page as the strobe one cycle earlier sees that earlier strobe's state update.
- R10: A load writes `ld_word` at `ld_idx`. A load on the edge where a state update would be written wins over it. A strobe sampled on the same edge as a load to its entry sees the loaded word.
- R11: While reset is high and after it is released, `xl_vld`, `xl_mapped`, `xl_state`, `xl_wen` and `xl_addr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_vld | input | 1 | Access strobe |
| acc_wr | input | 1 | Access is a write |
| acc_addr | input | 24 | CPU address |
| ld_en | input | 1 | Table load strobe |
| ld_idx | input | 10 | Entry index to load |
| ld_word | input | 16 | Map word to load |
| xl_vld | output | 1 | Result valid |
| xl_mapped | output | 1 | Result went through the table |
| xl_addr | output | 24 | Translated or passed-through address |
| xl_state | output | 2 | Page state seen by the access |
| xl_wen | output | 1 | Write-enable flag of the entry |

## Verification
The bench loads all 1024 entries with mixed page numbers, flags and states. It then issues back-to-back read, write, read triples on every page, so each state transition lands on the very next strobe. A design with no bypass around the table would report the stale state on the second and third strobes. A design that clobbers bit 15 or the page number during an update shows up in the last full pass. Absent pages are checked to stay absent, because a design that promoted them would later report state 2 or 3. A load on the same edge as a pending update, with a strobe to the same entry, catches a design that lets the update win or returns the pre-load word. Addresses above the window, including the top of the address space, must come back untouched.

// File: rtl/pmt_pkg.sv
package pmt_pkg;

  localparam int MAP_W = 16;
  localparam int PPN_W = 10;

  typedef enum logic [1:0] {
    PG_ABSENT = 2'd0,
    PG_FRESH  = 2'd1,
    PG_READ   = 2'd2,
    PG_DIRTY  = 2'd3
  } pg_state_e;

  // bit 15 write enable, 14:13 state, 12:10 spare, 9:0 physical page
  typedef struct packed {
    logic             wen;
    pg_state_e        st;
    logic [2:0]       spare;
    logic [PPN_W-1:0] ppn;
  } map_word_t;

endpackage

// File: rtl/map_table_ram.sv
module map_table_ram #(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic          re,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rq
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  // read returns the old word on a same-address collision
  always_ff @(posedge clk) begin
    if (re) rq <= mem[ra];
  end
endmodule

// File: rtl/page_status_next.sv
module page_status_next
  import pmt_pkg::*;
(
  input  pg_state_e cur,
  input  logic      wr,
  output pg_state_e nxt,
  output logic      chg
);
  always_comb begin
    nxt = cur;
    unique case (cur)
      PG_ABSENT: nxt = PG_ABSENT;
      PG_FRESH:  nxt = wr ? PG_DIRTY : PG_READ;
      PG_READ:   nxt = wr ? PG_DIRTY : PG_READ;
      PG_DIRTY:  nxt = PG_DIRTY;
      default:   nxt = cur;
    endcase
    chg = (nxt != cur);
  end
endmodule

// File: rtl/page_map_unit.sv
module page_map_unit
  import pmt_pkg::*;
#(
  parameter int VA_W  = 24,
  parameter int IDX_W = 10,
  parameter int OFF_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_vld,
  input  logic             acc_wr,
  input  logic [VA_W-1:0]  acc_addr,
  input  logic             ld_en,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [MAP_W-1:0] ld_word,
  output logic             xl_vld,
  output logic             xl_mapped,
  output logic [VA_W-1:0]  xl_addr,
  output logic [1:0]       xl_state,
  output logic             xl_wen
);
  localparam int WIN_W = IDX_W + OFF_W;
  localparam int PA_W  = PPN_W + OFF_W;

  // stage 0: decode
  logic             in_win;
  logic [IDX_W-1:0] rd_idx;
  logic             rd_en;

  assign in_win = (acc_addr[VA_W-1:WIN_W] == '0);
  assign rd_idx = acc_addr[WIN_W-1:OFF_W];
  assign rd_en  = acc_vld & in_win;

  // stage 1 registers
  logic             s1_vld, s1_map, s1_wr, s1_fwd;
  logic [VA_W-1:0]  s1_addr;
  logic [MAP_W-1:0] s1_fwd_word;
  logic [MAP_W-1:0] ram_q;
  logic [IDX_W-1:0] s1_idx;
  map_word_t        ent;

  // shared write port
  logic             wp_en;
  logic [IDX_W-1:0] wp_idx;
  logic [MAP_W-1:0] wp_data;

  // status update
  pg_state_e nxt_st;
  logic      st_chg;
  logic      wb_en;
  map_word_t wb_word;

  assign s1_idx = s1_addr[WIN_W-1:OFF_W];
  assign ent    = s1_fwd ? map_word_t'(s1_fwd_word) : map_word_t'(ram_q);

  page_status_next u_next (
    .cur (ent.st),
    .wr  (s1_wr),
    .nxt (nxt_st),
    .chg (st_chg)
  );

  assign wb_en = s1_vld & s1_map & st_chg;

  always_comb begin
    wb_word    = ent;
    wb_word.st = nxt_st;
  end

  // a table load takes the port over a pending history update
  assign wp_en   = ld_en | wb_en;
  assign wp_idx  = ld_en ? ld_idx  : s1_idx;
  assign wp_data = ld_en ? ld_word : MAP_W'(wb_word);

  map_table_ram #(.AW(IDX_W), .DW(MAP_W)) u_tbl (
    .clk (clk),
    .we  (wp_en),
    .wa  (wp_idx),
    .wd  (wp_data),
    .re  (rd_en),
    .ra  (rd_idx),
    .rq  (ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld      <= 1'b0;
      s1_map      <= 1'b0;
      s1_wr       <= 1'b0;
      s1_addr     <= '0;
      s1_fwd      <= 1'b0;
      s1_fwd_word <= '0;
    end else begin
      s1_vld      <= acc_vld;
      s1_map      <= rd_en;
      s1_wr       <= acc_wr;
      s1_addr     <= acc_addr;
      // the table read returns the old word, so bypass a write to the same entry
      s1_fwd      <= wp_en && (wp_idx == rd_idx);
      s1_fwd_word <= wp_data;
    end
  end

  // address splice
  logic [VA_W-1:0] phys_addr;

  generate
    if (VA_W > PA_W) begin : g_pad
      assign phys_addr = {{(VA_W-PA_W){1'b0}}, ent.ppn, s1_addr[OFF_W-1:0]};
    end else begin : g_trunc
      logic [PA_W-1:0] full_pa;
      assign full_pa   = {ent.ppn, s1_addr[OFF_W-1:0]};
      assign phys_addr = full_pa[VA_W-1:0];
    end
  endgenerate

  // stage 2: registered result
  always_ff @(posedge clk) begin
    if (rst) begin
      xl_vld    <= 1'b0;
      xl_mapped <= 1'b0;
      xl_addr   <= '0;
      xl_state  <= '0;
      xl_wen    <= 1'b0;
    end else begin
      xl_vld    <= s1_vld;
      xl_mapped <= s1_vld & s1_map;
      xl_addr   <= s1_map ? phys_addr : s1_addr;
      xl_state  <= s1_map ? ent.st : 2'd0;
      xl_wen    <= s1_map & ent.wen;
    end
  end

  // assertions
  p_pass_through_r1: assert property (@(posedge clk) disable iff (rst)
    acc_vld && !in_win |-> ##2 (xl_vld && !xl_mapped && xl_addr == $past(acc_addr, 2)));

  p_latency_r3: assert property (@(posedge clk) disable iff (rst)
    acc_vld |-> ##2 xl_vld);

  p_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !acc_vld |-> ##2 !xl_vld);

  p_fresh_read_r5: assert property (@(posedge clk) disable iff (rst)
    s1_vld && s1_map && !s1_wr && ent.st == PG_FRESH |-> nxt_st == PG_READ);

  p_write_dirty_r6: assert property (@(posedge clk) disable iff (rst)
    s1_vld && s1_map && s1_wr && ent.st != PG_ABSENT |-> nxt_st == PG_DIRTY);

  p_absent_hold_r7: assert property (@(posedge clk) disable iff (rst)
    s1_vld && s1_map && ent.st == PG_ABSENT && !ld_en |-> !wp_en);

  p_reset_quiet_r11: assert property (@(posedge clk)
    $past(rst) |-> !xl_vld);
endmodule

// File: tb/sim_page_map_unit.sv
module sim_page_map_unit;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_vld = 1'b0, acc_wr = 1'b0;
  logic [23:0] acc_addr = '0;
  logic        ld_en = 1'b0;
  logic [9:0]  ld_idx = '0;
  logic [15:0] ld_word = '0;
  logic        xl_vld, xl_mapped, xl_wen;
  logic [23:0] xl_addr;
  logic [1:0]  xl_state;

  always #(PERIOD/2) clk = ~clk;

  page_map_unit u0 (
    .clk(clk), .rst(rst), .acc_vld(acc_vld), .acc_wr(acc_wr), .acc_addr(acc_addr),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_word(ld_word),
    .xl_vld(xl_vld), .xl_mapped(xl_mapped), .xl_addr(xl_addr),
    .xl_state(xl_state), .xl_wen(xl_wen)
  );

  int total = 0;
  int bad = 0;
  logic [15:0] tbl [1024];

  // two-deep queue of expected results
  logic        pv1 = 0, pv2 = 0;
  logic [28:0] pe1, pe2;
  string       pt1, pt2;

  task automatic check(input string tag, input logic [28:0] act, input logic [28:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // one clock: check the result due now, then drive the next access and load
  task automatic step(input logic v, input logic [23:0] a, input logic w,
                      input logic le, input logic [9:0] li, input logic [15:0] lw,
                      input string tag);
    logic [28:0] exp;
    string       t;
    logic [15:0] e;
    logic [1:0]  st, ns;
    @(negedge clk);
    if (pv2) check(pt2, {xl_vld, xl_mapped, xl_addr, xl_state, xl_wen}, pe2);
    else     check("R3", {28'd0, xl_vld}, 29'd0);
    pv2 = pv1; pe2 = pe1; pt2 = pt1;
    if (le) tbl[li] = lw;
    exp = '0;
    t = tag;
    if (v) begin
      if (a >= 24'h400000) begin
        exp = {1'b1, 1'b0, a, 2'd0, 1'b0};
        if (t == "") t = "R1";
      end else begin
        e  = tbl[a[21:12]];
        st = e[14:13];
        exp = {1'b1, 1'b1, 2'b00, e[9:0], a[11:0], st, e[15]};
        ns = st;
        if (st == 2'd1) ns = w ? 2'd3 : 2'd2;
        else if (st == 2'd2 && w) ns = 2'd3;
        tbl[a[21:12]][14:13] = ns;
        if (t == "") t = (st == 2'd0) ? "R7" : (st == 2'd1) ? "R5" : "R6";
      end
    end
    pv1 = v; pe1 = exp; pt1 = t;
    acc_vld = v; acc_addr = a; acc_wr = w;
    ld_en = le; ld_idx = li; ld_word = lw;
  endtask

  task automatic idle();
    step(0, 24'd0, 0, 0, 10'd0, 16'd0, "");
  endtask

  initial begin
    #(PERIOD * 200000);
    bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: quiet outputs during reset
    check("R11", {xl_vld, xl_mapped, xl_addr, xl_state, xl_wen}, 29'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R11", {xl_vld, xl_mapped, xl_addr, xl_state, xl_wen}, 29'd0);

    // load every entry: mixed flag, state and page number
    for (int p = 0; p < 1024; p++) begin
      logic [15:0] w;
      w = {p[2], p[1:0], p[5:3], 10'((p * 37 + 5) % 1024)};
      step(0, 24'd0, 0, 1, 10'(p), w, "");
    end
    idle();

    // R2/R4 first look, then back-to-back promotions on each page (R5, R6, R7, R9)
    for (int p = 0; p < 1024; p++) begin
      logic [23:0] a;
      a = {2'b00, 10'(p), 12'((p * 13) % 4096)};
      step(1, a, 0, 0, 10'd0, 16'd0, (p % 4 == 0) ? "R2" : (p % 4 == 1) ? "R4" : "");
      step(1, a ^ 24'h000FFF, 1, 0, 10'd0, 16'd0, (p % 8 == 3) ? "R9" : "");
      step(1, a, 0, 0, 10'd0, 16'd0, "");
      if (p % 5 == 0) idle();
    end
    idle();

    // R1: addresses above the window, including the top
    step(1, 24'h400000, 1, 0, 10'd0, 16'd0, "R1");
    step(1, 24'hFFFFFF, 0, 0, 10'd0, 16'd0, "R1");
    step(1, 24'h7FF123, 1, 0, 10'd0, 16'd0, "R1");
    step(1, 24'hC00ABC, 0, 0, 10'd0, 16'd0, "R1");
    idle(); idle();

    // R10: load collides with a pending update to the same entry
    step(0, 24'd0, 0, 1, 10'd77, 16'h2155, "R10");
    idle();
    step(1, 24'h04D010, 0, 0, 10'd0, 16'd0, "R10");
    step(1, 24'h04D020, 0, 1, 10'd77, 16'hA0AA, "R10");
    step(1, 24'h04D030, 1, 0, 10'd0, 16'd0, "R10");
    step(1, 24'h04D040, 0, 0, 10'd0, 16'd0, "R10");
    idle(); idle();

    // R8: final pass, flag and page number intact, state as modelled
    for (int p = 0; p < 1024; p++)
      step(1, {2'b00, 10'(p), 12'h5A5}, 0, 0, 10'd0, 16'd0, "R8");
    idle(); idle(); idle();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule